// File: doc/BRIEF.md
# Interval Timer with Square-Wave Port Output

This block is a 16-bit down-counting interval timer for a parallel-port peripheral. It counts down once per bus clock. The host reaches it through byte-wide register writes and reads. A reload latch holds the start value. A control register picks between two modes: a single-shot count that raises one interrupt per arming, and a free-running count that reloads itself and produces a periodic interrupt.

The timer can also take over the most significant pin of a small 8-bit output port. In free-running mode that pin becomes a square wave. In single-shot mode it goes high once, at the end of the count. Reading the count's low byte acknowledges the interrupt.

Read data is combinational on `addr` at all times. The read side effect, clearing the flag, happens only on a clock edge where `rdEn` is high.

Top module: `ivtimer`

## Requirements
- R1: The counter decreases by one on every clock. Address 2 reads its low byte and address 3 reads its high byte, both from the live count.
- R2: A write to address 3 does four things. It stores the byte as the latch high byte. It loads the counter with {written byte, latch low byte}. It clears the interrupt flag and arms single-shot mode. It also clears the timer's port bit.
- R3: A write to address 2 or address 4 changes only the latch low byte, and the counter keeps its count. A write to address 5 sets the latch high byte and clears the flag without touching the counter. Addresses 4 and 5 read back the latch bytes.
- R4: Control bit 6 set selects free-running mode. In this mode a zero count is followed by the latch value, so the period is latch+1 cycles.
- R5: Control bit 6 clear selects single-shot mode. In this mode the count passes from 0 to 0xFFFF and keeps decreasing.
- R6: A timeout is a cycle where the count is zero and address 3 is not being written. A timeout sets the flag `irq` in free-running mode, and also in single-shot mode when the timer is armed. Single-shot mode disarms at its first timeout, so later wraps raise nothing.
- R7: A read strobe on address 2 clears `irq`, and one on address 3 does not. When a timeout and a clearing access fall in the same cycle, the flag stays set.
- R8: Control bit 7 set enables the port override. With the override on, each free-running timeout inverts port bit 7, starting from low after the arming write.
- R9: With the override on, a single-shot timeout drives port bit 7 high. The pin then stays high through later wraps.
- R10: Addresses 0 and 1 are the port data and direction registers. `pbOe` equals the direction register, with bit 7 forced to 1 when the override is on. `pbOut` bit 7 is the timer bit while the override is on. A read of address 0 gives, for each bit, `pbOut` where `pbOe` is set and `pbIn` elsewhere.
- R11: After reset the following are all zero: counter, latch, control, port registers and `irq`. The timer is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one count per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (side effects only) |
| addr | input | 3 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr` |
| irq | output | 1 | Timer interrupt flag |
| pbIn | input | 8 | Port pin inputs |
| pbOut | output | 8 | Port output values |
| pbOe | output | 8 | Port output enables |

## Verification
On every cycle the assertions check the count's step: decrement, reload in free-running mode, and load on an arming write. They also check that the flag clears after a low-byte read, that the flag holds when nothing touches it, that the pin toggles on free-running timeouts, and that the direction override works. Only the bench scenarios can show the things that span a whole period. These are the exact period for each latch value, the single interrupt and the single rising pin per arming across a full 65536-cycle wrap, the latch-only effect of the low-byte writes, and the priority of a timeout over a clear in the same cycle.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_PDATA = 3'd0,
    A_PDIR  = 3'd1,
    A_CLO   = 3'd2,
    A_CHI   = 3'd3,
    A_LLO   = 3'd4,
    A_LHI   = 3'd5,
    A_CTRL  = 3'd6,
    A_NONE  = 3'd7
  } regAddr_e;

  typedef struct packed {
    logic       loadCnt;
    logic [1:0] latWr;
    logic       reloadEn;
  } strobe_t;
endpackage

// File: rtl/ivt_datapath.sv
module ivt_datapath
  import ivt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [DATA_W-1:0]   wrData,
  output logic [2*DATA_W-1:0] cnt,
  output logic [2*DATA_W-1:0] latch,
  output logic                cntZero
);
  localparam int CNT_W = 2 * DATA_W;

  for (genvar b = 0; b < 2; b++) begin : g_latByte
    always_ff @(posedge clk) begin
      if (!rstN) latch[b*DATA_W +: DATA_W] <= '0;
      else if (stb.latWr[b]) latch[b*DATA_W +: DATA_W] <= wrData;
    end
  end

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN)                        cnt <= '0;
    else if (stb.loadCnt)             cnt <= {wrData, latch[DATA_W-1:0]};
    else if (cntZero && stb.reloadEn) cnt <= latch;
    else                              cnt <= cnt - CNT_W'(1);
  end
endmodule

// File: rtl/ivt_control.sv
module ivt_control
  import ivt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cntZero,
  output strobe_t           stb,
  output logic              irq,
  output logic              freeRun,
  output logic              pb7En,
  output logic              pb7Bit,
  output logic [DATA_W-1:0] pbData,
  output logic [DATA_W-1:0] pbDir
);
  localparam int EN_BIT = DATA_W - 1;
  localparam int FR_BIT = DATA_W - 2;

  logic wrHi, wrLoAny, wrLatHi, rdLo, timeout, fire, armed, clrIrq;

  assign wrHi    = wrEn && (addr == A_CHI);
  assign wrLoAny = wrEn && ((addr == A_CLO) || (addr == A_LLO));
  assign wrLatHi = wrEn && (addr == A_LHI);
  assign rdLo    = rdEn && (addr == A_CLO);

  assign stb.loadCnt  = wrHi;
  assign stb.latWr    = {wrHi || wrLatHi, wrLoAny};
  assign stb.reloadEn = freeRun;

  assign timeout = cntZero && !wrHi;
  assign fire    = timeout && (freeRun || armed);
  assign clrIrq  = wrHi || wrLatHi || rdLo;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freeRun <= 1'b0;
      pb7En   <= 1'b0;
      pbData  <= '0;
      pbDir   <= '0;
    end else if (wrEn) begin
      if (addr == A_CTRL) begin
        freeRun <= wrData[FR_BIT];
        pb7En   <= wrData[EN_BIT];
      end
      if (addr == A_PDATA) pbData <= wrData;
      if (addr == A_PDIR)  pbDir  <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                    armed <= 1'b0;
    else if (wrHi)                armed <= 1'b1;
    else if (timeout && !freeRun) armed <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)       irq <= 1'b0;
    else if (fire)   irq <= 1'b1;
    else if (clrIrq) irq <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   pb7Bit <= 1'b0;
    else if (wrHi)               pb7Bit <= 1'b0;
    else if (timeout && freeRun) pb7Bit <= ~pb7Bit;
    else if (fire)               pb7Bit <= 1'b1;
  end
endmodule

// File: rtl/ivt_portb.sv
module ivt_portb #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] pbData,
  input  logic [DATA_W-1:0] pbDir,
  input  logic              pb7En,
  input  logic              pb7Bit,
  input  logic [DATA_W-1:0] pbIn,
  output logic [DATA_W-1:0] pbOut,
  output logic [DATA_W-1:0] pbOe,
  output logic [DATA_W-1:0] pbRead
);
  localparam int TOP = DATA_W - 1;

  always_comb begin
    pbOut = pbData;
    pbOe  = pbDir;
    if (pb7En) begin
      pbOut[TOP] = pb7Bit;
      pbOe[TOP]  = 1'b1;
    end
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_pin
    assign pbRead[i] = pbOe[i] ? pbOut[i] : pbIn[i];
  end
endmodule

// File: rtl/ivtimer.sv
module ivtimer
  import ivt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  input  logic [DATA_W-1:0] pbIn,
  output logic [DATA_W-1:0] pbOut,
  output logic [DATA_W-1:0] pbOe
);
  localparam int CNT_W = 2 * DATA_W;

  strobe_t           stb;
  logic [CNT_W-1:0]  cnt, latch;
  logic              cntZero, freeRun, pb7En, pb7Bit;
  logic [DATA_W-1:0] pbData, pbDir, pbRead;

  ivt_control #(.DATA_W(DATA_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .cntZero(cntZero), .stb(stb), .irq(irq),
    .freeRun(freeRun), .pb7En(pb7En), .pb7Bit(pb7Bit),
    .pbData(pbData), .pbDir(pbDir)
  );

  ivt_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .cnt(cnt), .latch(latch), .cntZero(cntZero)
  );

  ivt_portb #(.DATA_W(DATA_W)) i_pb (
    .pbData(pbData), .pbDir(pbDir), .pb7En(pb7En), .pb7Bit(pb7Bit),
    .pbIn(pbIn), .pbOut(pbOut), .pbOe(pbOe), .pbRead(pbRead)
  );

  always_comb begin
    rdData = '0;
    case (addr)
      A_PDATA: rdData = pbRead;
      A_PDIR:  rdData = pbDir;
      A_CLO:   rdData = cnt[DATA_W-1:0];
      A_CHI:   rdData = cnt[CNT_W-1:DATA_W];
      A_LLO:   rdData = latch[DATA_W-1:0];
      A_LHI:   rdData = latch[CNT_W-1:DATA_W];
      A_CTRL:  rdData[DATA_W-1 -: 2] = {pb7En, freeRun};
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/ivtimer_chk.sv
module ivtimer_chk #(
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic                rdEn,
  input logic [2:0]          addr,
  input logic [DATA_W-1:0]   wrData,
  input logic                irq,
  input logic [DATA_W-1:0]   pbOut,
  input logic [DATA_W-1:0]   pbOe,
  input logic [2*DATA_W-1:0] cnt,
  input logic [2*DATA_W-1:0] latch,
  input logic                freeRun,
  input logic                pb7En
);
  localparam int TOP = DATA_W - 1;
  logic wrHi;
  assign wrHi = wrEn && (addr == 3'd3);

  p_count_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cnt != '0 && !wrHi) |=> cnt == $past(cnt) - 1'b1);

  p_arm_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrHi |=> (cnt == {$past(wrData), $past(latch[DATA_W-1:0])}) && !irq);

  p_reload_r4: assert property (@(posedge clk) disable iff (!rstN)
    (freeRun && cnt == '0 && !wrHi) |=> cnt == $past(latch));

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!freeRun && cnt == '0 && !wrHi) |=> cnt == '1);

  p_lo_read_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 3'd2 && cnt != '0) |=> !irq);

  p_irq_holds_r7: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !wrEn && !(rdEn && addr == 3'd2)) |=> irq);

  p_toggle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pb7En && freeRun && cnt == '0 && !wrEn) |=> pbOut[TOP] != $past(pbOut[TOP]));

  p_oe_force_r10: assert property (@(posedge clk) disable iff (!rstN)
    pb7En |-> pbOe[TOP]);
endmodule

bind ivtimer ivtimer_chk #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .wrData(wrData), .irq(irq), .pbOut(pbOut), .pbOe(pbOe),
  .cnt(cnt), .latch(latch), .freeRun(freeRun), .pb7En(pb7En)
);

// File: tb/test_ivtimer.sv
module test_ivtimer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0, rdEn = 1'b0;
  logic [2:0] addr = 3'd7;
  logic [7:0] wrData = 8'h00, pbIn = 8'hA5;
  logic [7:0] rdData, pbOut, pbOe;
  logic       irq;

  int nVec = 0, nBad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ivtimer i_ivtimer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq), .pbIn(pbIn),
    .pbOut(pbOut), .pbOe(pbOe)
  );

  task automatic check(string req, int act, int exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    idle();
    wrEn = 1'b0; addr = 3'd7;
  endtask

  task automatic rdSide(logic [2:0] a);
    rdEn = 1'b1; addr = a;
    idle();
    rdEn = 1'b0; addr = 3'd7;
  endtask

  task automatic peek(logic [2:0] a, output int v);
    addr = a; #1; v = int'(rdData);
  endtask

  task automatic arm(int ctrl, int L);
    wr(3'd6, 8'(ctrl));
    wr(3'd2, 8'(L & 255));
    wr(3'd3, 8'(L >> 8));
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    int v, lo, hi;
    int lens[7] = '{0, 1, 2, 3, 6, 256, 511};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R11: reset state
    peek(3'd2, v); check("R11 cnt lo", v, 0);
    peek(3'd3, v); check("R11 cnt hi", v, 0);
    peek(3'd6, v); check("R11 ctrl", v, 0);
    check("R11 irq", int'(irq), 0);
    check("R11 pbOe", int'(pbOe), 0);
    idle(); idle(); idle();
    check("R11 disarmed no irq on wrap", int'(irq), 0);

    // R1 R4 R5 R6 R8 R9 sweep: both modes, several latch values
    for (int mode = 0; mode < 2; mode++) begin
      foreach (lens[j]) begin
        int L = lens[j];
        int cyc = mode ? 2*(L+1)+3 : L+5;
        arm(mode ? 8'hC0 : 8'h80, L);
        for (int k = 0; k < cyc; k++) begin
          int c, n;
          if (mode) begin
            n = k / (L+1);
            c = L - (k % (L+1));
          end else begin
            n = (k > L) ? 1 : 0;
            c = (L - k) & 16'hFFFF;
          end
          peek(3'd2, lo); peek(3'd3, hi);
          check(mode ? "R4 count lo" : "R5 count lo", lo, c & 255);
          check(mode ? "R4 count hi" : "R1 count hi", hi, c >> 8);
          check("R6 irq", int'(irq), (n > 0) ? 1 : 0);
          check(mode ? "R8 pin toggle" : "R9 pin high", int'(pbOut[7]),
                mode ? (n & 1) : n);
          idle();
        end
      end
    end

    // R7: high read keeps flag, low read clears it; R6/R9 no second event
    arm(8'h80, 4);
    repeat (6) idle();
    check("R6 single-shot irq", int'(irq), 1);
    rdSide(3'd3);
    check("R7 hi read keeps irq", int'(irq), 1);
    rdSide(3'd2);
    check("R7 lo read clears irq", int'(irq), 0);
    repeat (65540) idle();
    check("R6 no irq after wrap", int'(irq), 0);
    check("R9 pin stays high", int'(pbOut[7]), 1);

    // R7: timeout and low read in the same cycle -> flag set
    arm(8'hC0, 3);
    repeat (3) idle();
    rdSide(3'd2);
    check("R7 set wins over clear", int'(irq), 1);

    // R3/R2: latch-only writes, then load
    arm(8'h00, 16);
    wr(3'd4, 8'h03);
    peek(3'd2, v); check("R3 latch lo write keeps count", v, 15);
    wr(3'd2, 8'h07);
    peek(3'd2, v); check("R3 cnt lo write keeps count", v, 14);
    peek(3'd4, v); check("R3 latch lo readback", v, 7);
    wr(3'd3, 8'h00);
    peek(3'd2, lo); peek(3'd3, hi);
    check("R2 load from latch", hi*256+lo, 7);
    repeat (8) idle();
    check("R2 armed timeout", int'(irq), 1);
    wr(3'd5, 8'h01);
    check("R3 latch hi clears irq", int'(irq), 0);
    peek(3'd5, v); check("R3 latch hi readback", v, 1);
    peek(3'd2, lo); peek(3'd3, hi);
    check("R3 latch hi keeps count", hi*256+lo, 16'hFFFE);

    // R10: port direction and override
    wr(3'd1, 8'h0F);
    wr(3'd0, 8'h3C);
    check("R10 oe plain", int'(pbOe), 8'h0F);
    check("R10 out plain", int'(pbOut), 8'h3C);
    peek(3'd0, v); check("R10 read plain", v, 8'hAC);
    arm(8'h80, 2);
    check("R10 oe forced", int'(pbOe), 8'h8F);
    check("R2 pin low after arm", int'(pbOut), 8'h3C);
    peek(3'd0, v); check("R10 read override low", v, 8'h2C);
    repeat (3) idle();
    check("R10 out override high", int'(pbOut), 8'hBC);
    peek(3'd0, v); check("R10 read override high", v, 8'hAC);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule